// File: doc/BRIEF.md
# Buffered-Program Command Loader

This block is the command front end for buffered flash programming. A host presents write cycles (address, 16-bit data) one per clock on a valid/ready input. The block recognises a two-cycle unlock prefix and a load command. It then takes a word-count cycle that names the target block and a run of data cycles, and stores those words in a 16-slot buffer indexed by the low four address bits. After the data cycles it accepts a confirm cycle. A valid confirm hands the buffer, its per-slot valid mask, the block number and the 16-word line address to a programming engine over a valid/ready output.

Every malformed sequence drops the block into a sticky abort mode, shown on `abort_flag`. In that mode every write is ignored except a three-cycle abort-exit sequence. An asynchronous hardware reset also clears the mode.

Back-pressure works as follows. A host write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. From the edge that takes a valid confirm, `pgm_valid` stays high and `wr_ready` stays low. During that time `pgm_words`, `pgm_mask`, `pgm_block`, `pgm_line` and `poll_dq7` hold their values. The handoff ends on the first edge where `pgm_ready` is high. One cycle later `pgm_valid` is low and `wr_ready` is high again.

Top module: `wbl_loader`

## Requirements
- R1: After reset, `wr_ready`=1, `pgm_valid`=0, `abort_flag`=0 and `poll_dq7`=0.
- R2: A complete sequence is accepted and handed off. The sequence is: data low byte AAh at address low 11 bits 555h; 55h at 2AAh; 25h at any address; a count cycle with data WC and the block number in address bits 21..15; WC+1 data cycles; 29h at an address whose bits 21..15 equal that block. On the cycle after the confirm is taken, `pgm_valid`=1. `pgm_block` then holds the block, and `pgm_line` holds bits 21..4 of the data addresses. Slot i of `pgm_words` (bits 16i+15..16i) holds the word for address low bits i.
- R3: A count WC greater than 15 aborts. WC=15 takes 16 data cycles and gives `pgm_mask`=FFFFh.
- R4: A data cycle whose address bits 21..4 differ from those of the first data cycle aborts.
- R5: Each data cycle uses up one count, even when it repeats an address. The last word written to a slot is the one kept. `pgm_mask` bit i is set only for the slots written in the current load.
- R6: After the last data cycle, any cycle other than a valid confirm aborts. This includes an extra data cycle.
- R7: A confirm whose address bits 21..15 differ from the block of the count cycle aborts.
- R8: In abort mode, `abort_flag`=1 and `pgm_valid` stays 0. Writes other than AAh/555h, 55h/2AAh, F0h/555h, issued in that order, are ignored. An incomplete or wrong exit sequence leaves the flag set. The full exit sequence clears it on the cycle after its third write.
- R9: Asserting `rst_n` low clears abort mode.
- R10: While `pgm_valid`=1, `poll_dq7` is the inverse of bit 7 of the last data word taken. Otherwise it is 0.
- R11: While `pgm_valid`=1, `wr_ready`=0, and the handoff outputs are stable until `pgm_ready`.
- R12: Outside abort mode, a cycle that breaks the unlock prefix returns the block to idle without aborting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write cycle present |
| wr_ready | output | 1 | Host write can be taken |
| wr_addr | input | 22 | Host write address |
| wr_data | input | 16 | Host write data |
| pgm_valid | output | 1 | Loaded buffer offered to the engine |
| pgm_ready | input | 1 | Engine takes the buffer |
| pgm_block | output | 7 | Block number from the count cycle |
| pgm_line | output | 18 | Address bits 21..4 of the data cycles |
| pgm_words | output | 256 | Buffer contents, slot i at bits 16i+15..16i |
| pgm_mask | output | 16 | Slots written in this load |
| poll_dq7 | output | 1 | Inverse of bit 7 of the last word while handing off |
| abort_flag | output | 1 | Sticky abort mode |

## Verification
A wrong count register shows up at the ports within a few cycles. It either raises `pgm_valid` one data cycle early, or it raises `abort_flag` on the confirm when the block should have accepted it. A stale line window or a stale valid mask can only be seen in the handoff payload and in the abort flag after the next data cycle. Both are checked right after the confirm. A lost abort state is visible the very next cycle on `abort_flag`, and also as a forbidden `pgm_valid` after a complete sequence has been issued in abort mode.

// File: rtl/wbl_pkg.sv
package wbl_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_WCNT, S_LOAD, S_FULL, S_HAND,
    S_ABT0, S_ABT1, S_ABT2
  } wbl_state_e;

  localparam int KEY_AW = 11;
  localparam logic [7:0] C_KEY1    = 8'hAA;
  localparam logic [7:0] C_KEY2    = 8'h55;
  localparam logic [7:0] C_LOADCMD = 8'h25;
  localparam logic [7:0] C_CONFIRM = 8'h29;
  localparam logic [7:0] C_EXIT    = 8'hF0;
  localparam logic [KEY_AW-1:0] A_KEY1 = 11'h555;
  localparam logic [KEY_AW-1:0] A_KEY2 = 11'h2AA;
endpackage

// File: rtl/wbl_wordbuf.sv
module wbl_wordbuf #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DEPTH*DATA_W-1:0] words,
  output logic [DEPTH-1:0]        mask
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = we && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[i*DATA_W +: DATA_W] <= '0;
        mask[i]                   <= 1'b0;
      end else if (clr) begin
        mask[i] <= 1'b0;
      end else if (hit) begin
        words[i*DATA_W +: DATA_W] <= wdata;
        mask[i]                   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbl_seq.sv
module wbl_seq
  import wbl_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int BLK_LSB = 15,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BLK_W  = ADDR_W - BLK_LSB,
  localparam int LINE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              taken,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output wbl_state_e        state,
  output logic              buf_we,
  output logic              buf_clr,
  output logic [BLK_W-1:0]  blk_q,
  output logic [LINE_W-1:0] line_q,
  output logic [DATA_W-1:0] last_q
);
  localparam logic [DATA_W-1:0] MAX_WC = DATA_W'(DEPTH - 1);

  logic [IDX_W-1:0] left_q;
  logic             first_q;
  logic is_key1, is_key2, is_exit, wc_ok, win_ok, blk_ok;

  assign is_key1 = (addr[KEY_AW-1:0] == A_KEY1) && (data[7:0] == C_KEY1);
  assign is_key2 = (addr[KEY_AW-1:0] == A_KEY2) && (data[7:0] == C_KEY2);
  assign is_exit = (addr[KEY_AW-1:0] == A_KEY1) && (data[7:0] == C_EXIT);
  assign wc_ok   = (data <= MAX_WC);
  assign win_ok  = first_q || (addr[ADDR_W-1:IDX_W] == line_q);
  assign blk_ok  = (addr[ADDR_W-1:BLK_LSB] == blk_q);

  assign buf_clr = acc && (state == S_WCNT) && wc_ok;
  assign buf_we  = acc && (state == S_LOAD) && win_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      left_q  <= '0;
      first_q <= 1'b0;
      blk_q   <= '0;
      line_q  <= '0;
      last_q  <= '0;
    end else if (state == S_HAND) begin
      if (taken) state <= S_IDLE;
    end else if (acc) begin
      unique case (state)
        S_IDLE: if (is_key1) state <= S_UNL1;
        S_UNL1: state <= is_key2 ? S_UNL2 : S_IDLE;
        S_UNL2: state <= (data[7:0] == C_LOADCMD) ? S_WCNT : S_IDLE;
        S_WCNT: begin
          if (wc_ok) begin
            state   <= S_LOAD;
            left_q  <= IDX_W'(data);
            first_q <= 1'b1;
            blk_q   <= addr[ADDR_W-1:BLK_LSB];
          end else begin
            state <= S_ABT0;
          end
        end
        S_LOAD: begin
          if (!win_ok) begin
            state <= S_ABT0;
          end else begin
            first_q <= 1'b0;
            line_q  <= addr[ADDR_W-1:IDX_W];
            last_q  <= data;
            left_q  <= left_q - 1'b1;
            if (left_q == '0) state <= S_FULL;
          end
        end
        S_FULL: state <= (data[7:0] == C_CONFIRM && blk_ok) ? S_HAND : S_ABT0;
        S_ABT0: if (is_key1) state <= S_ABT1;
        S_ABT1: state <= is_key2 ? S_ABT2 : S_ABT0;
        S_ABT2: state <= is_exit ? S_IDLE : S_ABT0;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbl_loader.sv
module wbl_loader
  import wbl_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int BLK_LSB = 15,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BLK_W  = ADDR_W - BLK_LSB,
  localparam int LINE_W = ADDR_W - IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    pgm_valid,
  input  logic                    pgm_ready,
  output logic [BLK_W-1:0]        pgm_block,
  output logic [LINE_W-1:0]       pgm_line,
  output logic [DEPTH*DATA_W-1:0] pgm_words,
  output logic [DEPTH-1:0]        pgm_mask,
  output logic                    poll_dq7,
  output logic                    abort_flag
);
  wbl_state_e  state;
  logic        acc, buf_we, buf_clr;
  logic [DATA_W-1:0] last_word;

  assign acc = wr_valid && wr_ready;

  wbl_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .BLK_LSB(BLK_LSB)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .taken(pgm_ready),
    .addr(wr_addr), .data(wr_data), .state(state),
    .buf_we(buf_we), .buf_clr(buf_clr),
    .blk_q(pgm_block), .line_q(pgm_line), .last_q(last_word)
  );

  wbl_wordbuf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
    .idx(wr_addr[IDX_W-1:0]), .wdata(wr_data),
    .words(pgm_words), .mask(pgm_mask)
  );

  assign pgm_valid  = (state == S_HAND);
  assign wr_ready   = !pgm_valid;
  assign poll_dq7   = pgm_valid && !last_word[7];
  assign abort_flag = (state == S_ABT0) || (state == S_ABT1) || (state == S_ABT2);
endmodule

// File: rtl/wbl_chk.sv
module wbl_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic [21:0]             wr_addr,
  input logic [DATA_W-1:0]       wr_data,
  input logic                    pgm_valid,
  input logic                    pgm_ready,
  input logic [DEPTH*DATA_W-1:0] pgm_words,
  input logic [DEPTH-1:0]        pgm_mask,
  input logic                    poll_dq7,
  input logic                    abort_flag
);
  logic exit_cyc;
  assign exit_cyc = wr_valid && wr_ready && (wr_addr[10:0] == 11'h555) && (wr_data[7:0] == 8'hF0);

  // R11
  hand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid && !pgm_ready |=> pgm_valid && $stable(pgm_words) && $stable(pgm_mask));
  // R11
  no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid |-> !wr_ready);
  // R8
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag && !exit_cyc |=> abort_flag);
  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag |-> !pgm_valid);
  // R10
  poll_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_valid |-> !poll_dq7);
  // R2
  mask_some_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid |-> (pgm_mask != '0));
endmodule

bind wbl_loader wbl_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .pgm_valid(pgm_valid),
  .pgm_ready(pgm_ready), .pgm_words(pgm_words), .pgm_mask(pgm_mask),
  .poll_dq7(poll_dq7), .abort_flag(abort_flag)
);

// File: tb/wbl_loader_tb_top.sv
module wbl_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [21:0]  wr_addr = '0;
  logic [15:0]  wr_data = '0;
  logic         pgm_valid;
  logic         pgm_ready = 1'b0;
  logic [6:0]   pgm_block;
  logic [17:0]  pgm_line;
  logic [255:0] pgm_words;
  logic [15:0]  pgm_mask;
  logic         poll_dq7;
  logic         abort_flag;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbl_loader dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .pgm_valid(pgm_valid),
    .pgm_ready(pgm_ready), .pgm_block(pgm_block), .pgm_line(pgm_line),
    .pgm_words(pgm_words), .pgm_mask(pgm_mask), .poll_dq7(poll_dq7),
    .abort_flag(abort_flag)
  );

  typedef struct packed {
    logic [21:0] a;
    logic [15:0] d;
    logic        ab;
    logic        pv;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{22'h000555, 16'h00AA, 1'b0, 1'b0},
    '{22'h0002AA, 16'h0055, 1'b0, 1'b0},
    '{22'h028000, 16'h0025, 1'b0, 1'b0},
    '{22'h028000, 16'h0002, 1'b0, 1'b0},
    '{22'h028123, 16'h1111, 1'b0, 1'b0},
    '{22'h028125, 16'h2222, 1'b0, 1'b0},
    '{22'h028123, 16'h00F3, 1'b0, 1'b0},
    '{22'h028000, 16'h0029, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic prefix(input logic [21:0] ba, input logic [15:0] wc);
    wr(22'h000555, 16'h00AA);
    wr(22'h0002AA, 16'h0055);
    wr(ba, 16'h0025);
    wr(ba, wc);
  endtask

  task automatic exit_seq();
    wr(22'h000555, 16'h00AA);
    wr(22'h0002AA, 16'h0055);
    wr(22'h000555, 16'h00F0);
  endtask

  task automatic take();
    pgm_ready = 1'b1;
    @(negedge clk);
    pgm_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 wr_ready", 32'(wr_ready), 1);
    chk("R1 pgm_valid", 32'(pgm_valid), 0);
    chk("R1 abort_flag", 32'(abort_flag), 0);
    chk("R1 poll_dq7", 32'(poll_dq7), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R5 table: repeated slot, last write wins
    for (int i = 0; i < 8; i++) begin
      wr(VECS[i].a, VECS[i].d);
      chk($sformatf("R2 vec%0d abort", i), 32'(abort_flag), 32'(VECS[i].ab));
      chk($sformatf("R2 vec%0d pgm_valid", i), 32'(pgm_valid), 32'(VECS[i].pv));
    end
    chk("R2 block", 32'(pgm_block), 5);
    chk("R2 line", 32'(pgm_line), 32'h2812);
    chk("R5 slot3 last wins", 32'(pgm_words[3*16 +: 16]), 32'h00F3);
    chk("R2 slot5", 32'(pgm_words[5*16 +: 16]), 32'h2222);
    chk("R5 mask", 32'(pgm_mask), 32'h0028);
    chk("R10 poll bit7=1", 32'(poll_dq7), 0);
    // R11 hold under back-pressure, write offered but not taken
    wr(22'h000555, 16'h00AA);
    @(negedge clk);
    chk("R11 wr_ready low", 32'(wr_ready), 0);
    chk("R11 still valid", 32'(pgm_valid), 1);
    chk("R11 slot3 stable", 32'(pgm_words[3*16 +: 16]), 32'h00F3);
    take();
    chk("R11 released", 32'(pgm_valid), 0);
    chk("R11 ready back", 32'(wr_ready), 1);
    chk("R10 poll idle", 32'(poll_dq7), 0);

    // R3 boundary WC=15, 16 words; last word bit7=0
    prefix(22'h028000, 16'd15);
    for (int i = 0; i < 16; i++) wr(22'h028200 | 22'(i), 16'(i * 16'h0101));
    chk("R3 wc15 no early valid", 32'(pgm_valid), 0);
    wr(22'h028000, 16'h0029);
    chk("R3 wc15 valid", 32'(pgm_valid), 1);
    chk("R3 wc15 mask", 32'(pgm_mask), 32'hFFFF);
    chk("R2 slot9", 32'(pgm_words[9*16 +: 16]), 32'h0909);
    chk("R10 poll bit7=0", 32'(poll_dq7), 1);
    take();

    // R5 mask cleared by new load
    prefix(22'h028000, 16'd0);
    wr(22'h028206, 16'h0080);
    wr(22'h028000, 16'h0029);
    chk("R5 mask fresh", 32'(pgm_mask), 32'h0040);
    take();

    // R3 WC=16 aborts
    prefix(22'h028000, 16'd16);
    chk("R3 wc16 abort", 32'(abort_flag), 1);
    // R8 full sequence ignored in abort
    prefix(22'h028000, 16'd0);
    wr(22'h028200, 16'h1234);
    wr(22'h028000, 16'h0029);
    chk("R8 still abort", 32'(abort_flag), 1);
    chk("R8 no valid", 32'(pgm_valid), 0);
    wr(22'h000555, 16'h00AA);
    wr(22'h0002AA, 16'h0055);
    wr(22'h000555, 16'h0000);
    chk("R8 bad exit kept", 32'(abort_flag), 1);
    exit_seq();
    chk("R8 exit clears", 32'(abort_flag), 0);

    // R4 window mismatch
    prefix(22'h028000, 16'd3);
    wr(22'h028120, 16'h0001);
    chk("R4 first ok", 32'(abort_flag), 0);
    wr(22'h028130, 16'h0002);
    chk("R4 window abort", 32'(abort_flag), 1);
    exit_seq();

    // R6 extra data cycle
    prefix(22'h028000, 16'd0);
    wr(22'h028120, 16'h0001);
    wr(22'h028121, 16'h0002);
    chk("R6 extra data abort", 32'(abort_flag), 1);
    exit_seq();
    // R6 other command
    prefix(22'h028000, 16'd0);
    wr(22'h028120, 16'h0001);
    wr(22'h000555, 16'h00F0);
    chk("R6 other cmd abort", 32'(abort_flag), 1);
    exit_seq();

    // R7 wrong confirm block
    prefix(22'h028000, 16'd0);
    wr(22'h028120, 16'h0001);
    wr(22'h030000, 16'h0029);
    chk("R7 block mismatch abort", 32'(abort_flag), 1);
    chk("R7 no valid", 32'(pgm_valid), 0);

    // R9 hardware reset clears
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset clears abort", 32'(abort_flag), 0);
    chk("R9 ready", 32'(wr_ready), 1);

    // R12 broken prefix returns idle without abort
    wr(22'h000555, 16'h00AA);
    wr(22'h000000, 16'h0000);
    wr(22'h0002AA, 16'h0055);
    wr(22'h028000, 16'h0025);
    wr(22'h028000, 16'h0020);
    chk("R12 no abort", 32'(abort_flag), 0);
    chk("R12 no valid", 32'(pgm_valid), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule